// File: doc/BRIEF.md
# Truncated Geometric FIR Filter

This block filters a stream of signed samples with a finite impulse response whose taps form a cut-off geometric series: tap k equals a^k for k = 0 to LEN−1 and every later tap is zero. It does not use a tapped delay line with one multiplier per tap. A comb section subtracts the sample that left the window, scaled by a^LEN. A first-order feedback section then multiplies its previous result by a and adds the comb output. The pole at a cancels the first zero of the comb, so the cascade costs two constant multiplies and two adds per sample, whatever LEN is.

The ratio is a = A / 2^F, an integer A over a power of two with |A| < 2^F. The constant A_POW = A^LEN is passed in as its own parameter, and elaboration rejects a value that is not exact. Internally, every value is scaled by 2^(LEN·F). At that scale each product the recurrence forms is an integer and divides exactly by 2^F. The pole and zero therefore cancel bit for bit and no error builds up in the loop. When A is a power of two, each multiplier becomes a shift.

Samples enter with `in_valid`. Each accepted sample yields one result on `out_valid`. Cycles without `in_valid` do not advance the filter.

Top module: `gfir_geo7`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: Feed a single sample of value v followed by zeros. The outputs are v·A^k·2^((LEN−1−k)·F) for k = 0..LEN−1, and exactly 0 from the LEN-th output onward.
- R3: For any input sequence, `out_data` equals the direct-form sum Σ_{k=0}^{LEN−1} A^k·2^((LEN−1−k)·F)·x(n−k) over the last LEN accepted samples. This is y(n) in two's complement with (LEN−1)·F fraction bits.
- R4: An input accepted at a rising edge produces `out_valid` high exactly two rising edges later. `out_valid` is low in every other cycle.
- R5: When `in_valid` is low, the sample history is left unchanged and `out_data` keeps its last value.
- R6: A reset in the middle of a stream clears both the comb history and the feedback register together. The results after reset depend only on samples accepted after reset.
- R7: Full-scale inputs (sustained +2^(IN_W−1)−1, sustained −2^(IN_W−1), and alternating between the two) give exact results with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Result strobe, two edges after the sample |
| out_data | output | IN_W+clog2(LEN)+1+(LEN−1)·F | Signed result with (LEN−1)·F fraction bits |

## Verification
A sample sampled at edge E is registered by the comb at E, and its result appears in the feedback register at E+1. The bench therefore reads outputs 2 ns after each rising edge and compares them with the entry that its reference pipeline moved into the output slot at that same edge. Reset acts at once. The result of the first sample after reset is due two edges later, like any other result. In cycles without a result, the bench expects the previous value to be held.

// File: rtl/gfir_pkg.sv
package gfir_pkg;

   function automatic longint ipow(longint base, int expo);
      longint r = 1;
      for (int i = 0; i < expo; i++) r = r * base;
      return r;
   endfunction

   // Width of the scaled state: magnitude <= 2^(in_w-1) * len * 2^(len*f), plus sign and margin
   function automatic int acc_width(int in_w, int len, int f);
      return in_w + $clog2(len) + 1 + len * f;
   endfunction

   // Exponent of k when k is a positive power of two, otherwise -1
   function automatic int log2_exact(longint k);
      for (int i = 0; i < 62; i++)
         if ((longint'(1) << i) == k) return i;
      return -1;
   endfunction

   // Largest possible output magnitude at output scale
   function automatic longint peak_mag(int in_w, int len, int f, longint a);
      longint mag = (a < 0) ? -a : a;
      longint s = 0;
      longint ak = 1;
      for (int k = 0; k < len; k++) begin
         s = s + ak * (longint'(1) << ((len - 1 - k) * f));
         ak = ak * mag;
      end
      return s * (longint'(1) << (in_w - 1));
   endfunction

endpackage

// File: rtl/gfir_cmul.sv
module gfir_cmul #(
   parameter int     DW = 12,
   parameter int     RW = 30,
   parameter longint K  = 1
) (
   input  logic signed [DW-1:0] d,
   output logic signed [RW-1:0] p
);
   localparam int SH = gfir_pkg::log2_exact(K);

   if (RW <= DW) begin : g_bad_width
      $error("gfir_cmul: result width must exceed data width");
   end

   logic signed [RW-1:0] d_ext;
   assign d_ext = {{(RW-DW){d[DW-1]}}, d};

   if (SH >= 0) begin : g_shift
      assign p = d_ext <<< SH;
   end else begin : g_mult
      localparam logic signed [RW-1:0] KC = RW'(K);
      assign p = d_ext * KC;
   end
endmodule

// File: rtl/gfir_comb.sv
module gfir_comb #(
   parameter int     IN_W  = 12,
   parameter int     LEN   = 7,
   parameter int     F     = 2,
   parameter longint A_POW = 2187,
   parameter int     ACC_W = 30
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_data,
   output logic                    w_valid,
   output logic signed [ACC_W-1:0] w_data
);
   localparam int UP = LEN * F;

   logic signed [IN_W-1:0]  tap [LEN];
   logic signed [ACC_W-1:0] cancel;
   logic signed [ACC_W-1:0] x_scaled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LEN; i++) tap[i] <= '0;
      end else if (in_valid) begin
         tap[0] <= in_data;
         for (int i = 1; i < LEN; i++) tap[i] <= tap[i-1];
      end
   end

   gfir_cmul #(.DW(IN_W), .RW(ACC_W), .K(A_POW)) u_zero (
      .d (tap[LEN-1]),
      .p (cancel)
   );

   assign x_scaled = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data} <<< UP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_valid <= 1'b0;
         w_data  <= '0;
      end else begin
         w_valid <= in_valid;
         if (in_valid) w_data <= x_scaled - cancel;
      end
   end
endmodule

// File: rtl/gfir_pole.sv
module gfir_pole #(
   parameter int     ACC_W = 30,
   parameter int     F     = 2,
   parameter longint A     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    w_valid,
   input  logic signed [ACC_W-1:0] w_data,
   output logic                    y_valid,
   output logic signed [ACC_W-1:0] y_acc
);
   localparam int A_W = F + 2;
   localparam int RW  = ACC_W + A_W;

   logic signed [RW-1:0]    fb_full;
   logic signed [ACC_W-1:0] fb;
   logic                    fb_unused;

   gfir_cmul #(.DW(ACC_W), .RW(RW), .K(A)) u_fb (
      .d (y_acc),
      .p (fb_full)
   );

   // the state is a multiple of 2^F, so dropping the low bits is exact
   assign fb        = fb_full[F +: ACC_W];
   assign fb_unused = ^{fb_full[RW-1:F+ACC_W], fb_full[F-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_valid <= 1'b0;
         y_acc   <= '0;
      end else begin
         y_valid <= w_valid;
         if (w_valid) y_acc <= fb + w_data;
      end
   end
endmodule

// File: rtl/gfir_geo7.sv
module gfir_geo7 #(
   parameter int     IN_W  = 12,
   parameter int     LEN   = 7,
   parameter int     F     = 2,
   parameter longint A     = 3,
   parameter longint A_POW = 2187
) (
   input  logic                                                  clk,
   input  logic                                                  rst_n,
   input  logic                                                  in_valid,
   input  logic signed [IN_W-1:0]                                in_data,
   output logic                                                  out_valid,
   output logic signed [gfir_pkg::acc_width(IN_W, LEN, F)-F-1:0] out_data
);
   localparam int ACC_W = gfir_pkg::acc_width(IN_W, LEN, F);

   if (LEN < 2) begin : g_bad_len
      $error("gfir_geo7: LEN must be at least 2");
   end
   if (F < 1) begin : g_bad_frac
      $error("gfir_geo7: F must be at least 1");
   end
   if (A >= (longint'(1) << F) || A <= -(longint'(1) << F)) begin : g_bad_ratio
      $error("gfir_geo7: |A| must be below 2^F");
   end
   if (A_POW != gfir_pkg::ipow(A, LEN)) begin : g_bad_pow
      $error("gfir_geo7: A_POW must equal A^LEN exactly");
   end

   logic                    w_valid;
   logic signed [ACC_W-1:0] w_data;
   logic signed [ACC_W-1:0] y_acc;
   logic                    y_lo_unused;

   gfir_comb #(.IN_W(IN_W), .LEN(LEN), .F(F), .A_POW(A_POW), .ACC_W(ACC_W)) u_comb (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .w_valid  (w_valid),
      .w_data   (w_data)
   );

   gfir_pole #(.ACC_W(ACC_W), .F(F), .A(A)) u_pole (
      .clk     (clk),
      .rst_n   (rst_n),
      .w_valid (w_valid),
      .w_data  (w_data),
      .y_valid (out_valid),
      .y_acc   (y_acc)
   );

   assign out_data    = y_acc[ACC_W-1:F];
   assign y_lo_unused = ^y_acc[F-1:0];
endmodule

// File: rtl/gfir_geo7_chk.sv
module gfir_geo7_chk #(
   parameter int     IN_W = 12,
   parameter int     LEN  = 7,
   parameter int     F    = 2,
   parameter longint A    = 3
) (
   input logic                                                  clk,
   input logic                                                  rst_n,
   input logic                                                  in_valid,
   input logic signed [IN_W-1:0]                                in_data,
   input logic                                                  out_valid,
   input logic signed [gfir_pkg::acc_width(IN_W, LEN, F)-F-1:0] out_data
);
   localparam longint PEAK = gfir_pkg::peak_mag(IN_W, LEN, F, A);

   // zero samples seen in a row, saturating at LEN; reset history counts as zeros
   int zrun;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zrun <= LEN;
      else if (in_valid) zrun <= (in_data != 0) ? 0 : ((zrun >= LEN) ? LEN : zrun + 1);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_cleared: assert (!out_valid && out_data == 0)
            else $error("R1: outputs not cleared in reset");
      end
   end

   a_r2_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data == 0 && zrun >= LEN - 1) |=> ##1 (out_data == 0))
      else $error("R2: window of zeros gave non-zero result");

   a_r4_result_due: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid)
      else $error("R4: result missing two edges after sample");

   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid)
      else $error("R4: result without sample");

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && $past(rst_n)) |-> $stable(out_data))
      else $error("R5: output moved without result");

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data <= PEAK && out_data >= -PEAK))
      else $error("R7: output outside reachable range");
endmodule

bind gfir_geo7 gfir_geo7_chk #(.IN_W(IN_W), .LEN(LEN), .F(F), .A(A)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/test_gfir_geo7.sv
module test_gfir_geo7;
   localparam int     IN_W  = 12;
   localparam int     LEN   = 7;
   localparam int     F     = 2;
   localparam longint A     = 3;
   localparam longint A_POW = 2187;
   localparam int     OUT_W = IN_W + $clog2(LEN) + 1 + (LEN - 1) * F;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic signed [IN_W-1:0]  in_data = '0;
   logic                    out_valid;
   logic signed [OUT_W-1:0] out_data;

   int    errors = 0;
   int    checks = 0;
   string phase = "R1";
   bit    done = 1'b0;

   always #4 clk = ~clk;

   gfir_geo7 #(.IN_W(IN_W), .LEN(LEN), .F(F), .A(A), .A_POW(A_POW)) i_gfir_geo7 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // reference: history queue and the tap-by-tap sum
   longint hist[$];
   bit     p1_v, exp_v;
   longint p1_d, exp_d;

   function automatic longint direct_form();
      longint s = 0;
      longint ak = 1;
      for (int k = 0; k < LEN; k++) begin
         s  = s + hist[k] * ak * (longint'(1) << ((LEN - 1 - k) * F));
         ak = ak * A;
      end
      return s;
   endfunction

   task automatic clear_model();
      hist.delete();
      for (int k = 0; k < LEN; k++) hist.push_back(0);
      p1_v = 1'b0; p1_d = 0; exp_v = 1'b0; exp_d = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) clear_model();
      else begin
         exp_v = p1_v;
         if (p1_v) exp_d = p1_d;
         p1_v = in_valid;
         if (in_valid) begin
            hist.push_front(longint'(in_data));
            void'(hist.pop_back());
            p1_d = direct_form();
         end
      end
   end

   task automatic check(string req, longint act, longint expv, string what);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) begin
         if (!rst_n) begin
            check("R1", longint'(out_valid), 0, "valid during reset");
            check("R1", longint'(out_data), 0, "data during reset");
         end else begin
            check("R4", longint'(out_valid), longint'(exp_v), "valid timing");
            check(out_valid ? phase : "R5", longint'(out_data), exp_d, "data");
         end
      end
   end

   task automatic put(bit v, logic signed [IN_W-1:0] d);
      @(negedge clk);
      in_valid = v;
      in_data  = d;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      put(0, 0);
      // R2: impulse, then a negative full-scale impulse
      phase = "R2";
      put(1, 1);
      repeat (12) put(1, 0);
      put(1, -2048);
      repeat (10) put(1, 0);
      // R3: dense random stream
      phase = "R3";
      repeat (60) put(1, IN_W'($urandom));
      // R5: random stream with gaps
      phase = "R5";
      repeat (80) put(1'($urandom_range(0, 1)), IN_W'($urandom));
      // R7: full-scale extremes
      phase = "R7";
      repeat (12) put(1, 2047);
      repeat (12) put(1, -2048);
      for (int i = 0; i < 10; i++) begin
         put(1, 2047);
         put(1, -2048);
      end
      // R6: reset in the middle of a stream
      phase = "R6";
      repeat (5) put(1, IN_W'($urandom));
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b1; in_data = 12'sd777;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; in_valid = 1'b0;
      put(1, 100);
      repeat (20) put(1, IN_W'($urandom));
      repeat (6) put(0, 0);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL R4 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule